// File: doc/BRIEF.md
# Firmware Hub Device Select and Block Protection Guard

This block is the control front end of a flash device that sits on a 4-bit firmware-hub or LPC style bus. It combines the two active-low reset inputs into one internal reset. While that reset is active it captures the interface-mode pin. It follows the active-low frame strobe to see when a bus operation starts and when one is aborted. It decides whether the current cycle is addressed to this device. In firmware-hub cycles the carried 4-bit ID is compared with the four strap inputs. In LPC cycles two address bits are compared with the two upper straps in inverted sense.

A separate cycle decoder, not part of this block, announces when the ID or address is valid, when an operation ends, and when a program or erase request arrives. For each request the guard checks the per-block lock bits and the top-block lock pin. It then either starts the array operation or drops the request and sets a sticky denial flag. The block answers with a select output, an output-drive enable that is held low during reset, a read-mode indication and an active flag for the array operation.

Top module: `fwh_sel_guard`

## Requirements
- R1: The internal reset is active when `bus_rst_n` or `cpu_rst_n` is low. While it is active, `busy`, `sel`, `abort_p`, `pe_active`, `denied` and `drv_en` are 0 and `read_mode` is 1, and this takes effect without waiting for a clock edge.
- R2: `if_sel_i` is captured into `mux_mode` on every clock edge while the internal reset is active. Once the reset is released, `mux_mode` keeps its value whatever the pin does (0 = firmware-hub/LPC bus, 1 = address-multiplexed interface).
- R3: With `mux_mode`=0 and `busy`=0, a low `frame_n` at a rising edge sets `busy` from that edge.
- R4: With `busy`=1, a low `frame_n` at a rising edge clears `busy` and `sel` and raises `abort_p` for exactly one cycle. In that cycle the abort wins over `hdr_vld` and `op_done`.
- R5: In a firmware-hub cycle (`lpc_cyc`=0), a rising edge with `busy`=1, `frame_n`=1 and `hdr_vld`=1 sets `sel` when `cyc_id` equals `strap_id` on all four bits. Otherwise `sel` is left as it was.
- R6: In an LPC cycle (`lpc_cyc`=1), the match needs `addr[21]` != `strap_id[3]` and `addr[20]` != `strap_id[2]`. `strap_id[1:0]` and `cyc_id` play no part.
- R7: `op_done` at a rising edge with `busy`=1 and `frame_n`=1 clears `busy` and `sel`. `drv_en` is 1 exactly when `sel` is 1 and the internal reset is released.
- R8: While `mux_mode`=1, `busy` and `sel` stay 0 whatever `frame_n` and `hdr_vld` do.
- R9: A `pe_req` is taken at a rising edge when `pe_active`=0 and either `sel`=1 or `mux_mode`=1. The block number is `addr[19:16]`. If `lock_bits[block]`=1 the request is denied and `pe_active` stays 0. Otherwise `pe_active` is set.
- R10: For block 15 only, `top_lock_n`=0 also denies the request whatever `lock_bits[15]` holds. Blocks 0 to 14 ignore `top_lock_n`.
- R11: `pe_active` stays 1 until `pe_done` is seen at a rising edge. Changes to `lock_bits` or `top_lock_n` while it is active have no effect. `read_mode` equals the inverse of `pe_active`.
- R12: `denied` is set by a denied request and stays set until `denied_clr` is seen at a rising edge. If a denial and `denied_clr` fall on the same edge, `denied` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Interface reset, active low |
| cpu_rst_n | input | 1 | Processor reset, active low |
| if_sel_i | input | 1 | Interface-mode pin, captured during reset |
| frame_n | input | 1 | Frame strobe, active low |
| hdr_vld | input | 1 | Cycle ID and address are valid this cycle |
| lpc_cyc | input | 1 | Current cycle uses the LPC form of matching |
| cyc_id | input | 4 | ID carried by a firmware-hub cycle |
| addr | input | 22 | Cycle address |
| strap_id | input | 4 | Device identification straps |
| op_done | input | 1 | Current bus operation finished normally |
| pe_req | input | 1 | Program or erase request |
| pe_done | input | 1 | Array operation finished |
| lock_bits | input | 16 | Per-block lock bits, 1 = locked |
| top_lock_n | input | 1 | Top-block lock pin, active low |
| denied_clr | input | 1 | Clears the sticky denial flag |
| mux_mode | output | 1 | Captured interface mode |
| busy | output | 1 | Bus operation in progress |
| abort_p | output | 1 | One-cycle pulse on an aborted operation |
| sel | output | 1 | This device is addressed |
| drv_en | output | 1 | Bus output-drive enable |
| read_mode | output | 1 | Array is in read mode |
| pe_active | output | 1 | Program or erase operation running |
| denied | output | 1 | Sticky flag: a request was denied |

## Verification
Two pairs of events can fall on the same clock edge. In the first, a frame-low abort meets an `hdr_vld` whose ID matches. The bench provokes it by holding `frame_n` low for a second cycle while presenting a matching header, and it requires that `abort_p` rises while `sel` and `busy` end at 0. In the second, a denied request meets `denied_clr`. The bench issues both on the same edge and requires `denied` to stay 1. A behavioural reference model then runs randomised frames, headers, lock patterns and resets, and every output is compared with it on every cycle.

// File: rtl/fwh_guard_pkg.sv
package fwh_guard_pkg;

  typedef enum logic {
    FT_IDLE = 1'b0,
    FT_BUSY = 1'b1
  } ft_state_e;

endpackage

// File: rtl/fwh_rst_mode.sv
module fwh_rst_mode (
  input  logic clk,
  input  logic bus_rst_n,
  input  logic cpu_rst_n,
  input  logic if_sel_i,
  output logic rst_n_int,
  output logic mux_mode
);

  // Either active-low source holds the whole block in reset.
  assign rst_n_int = bus_rst_n & cpu_rst_n;

  logic mode_q;

  // The mode pin is only looked at while reset is active.
  always_ff @(posedge clk) begin
    if (!rst_n_int) mode_q <= if_sel_i;
  end

  assign mux_mode = mode_q;

endmodule

// File: rtl/fwh_frame_trk.sv
module fwh_frame_trk
  import fwh_guard_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int ADDR_W  = 22,
  parameter int LPC_LSB = 20,
  parameter int LPC_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode,
  input  logic              frame_n,
  input  logic              hdr_vld,
  input  logic              lpc_cyc,
  input  logic [ID_W-1:0]   cyc_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   strap_id,
  input  logic              op_done,
  output logic              busy,
  output logic              sel,
  output logic              abort_p,
  output logic              ev_start,
  output logic              ev_abort,
  output logic              ev_hit
);

  // Firmware-hub form: every strap bit must equal the carried ID bit.
  function automatic logic fwh_hit(input logic [ID_W-1:0] id,
                                   input logic [ID_W-1:0] strap);
    return id == strap;
  endfunction

  // LPC form: upper straps are compared in inverted sense.
  function automatic logic lpc_hit(input logic [LPC_W-1:0] abits,
                                   input logic [LPC_W-1:0] strap_hi);
    return abits == ~strap_hi;
  endfunction

  ft_state_e st_q;
  logic      sel_q;
  logic      abort_q;
  logic      id_hit;

  assign id_hit = lpc_cyc ? lpc_hit(addr[LPC_LSB +: LPC_W], strap_id[ID_W-1 -: LPC_W])
                          : fwh_hit(cyc_id, strap_id);

  assign ev_start = !mux_mode && (st_q == FT_IDLE) && !frame_n;
  assign ev_abort = !mux_mode && (st_q == FT_BUSY) && !frame_n;
  assign ev_hit   = !mux_mode && (st_q == FT_BUSY) && frame_n && !op_done
                    && hdr_vld && id_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FT_IDLE;
      sel_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (mux_mode) begin
        st_q  <= FT_IDLE;
        sel_q <= 1'b0;
      end else begin
        unique case (st_q)
          FT_IDLE: begin
            if (!frame_n) begin
              st_q  <= FT_BUSY;
              sel_q <= 1'b0;
            end
          end
          FT_BUSY: begin
            if (!frame_n) begin
              st_q    <= FT_IDLE;
              sel_q   <= 1'b0;
              abort_q <= 1'b1;
            end else if (op_done) begin
              st_q  <= FT_IDLE;
              sel_q <= 1'b0;
            end else if (hdr_vld && id_hit) begin
              sel_q <= 1'b1;
            end
          end
          default: st_q <= FT_IDLE;
        endcase
      end
    end
  end

  assign busy    = (st_q == FT_BUSY);
  assign sel     = sel_q;
  assign abort_p = abort_q;

endmodule

// File: rtl/fwh_lock_gate.sv
module fwh_lock_gate #(
  parameter int N_BLK   = 16,
  parameter int ADDR_W  = 22,
  parameter int BLK_LSB = 16,
  localparam int BLK_W  = $clog2(N_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_ok,
  input  logic              pe_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_BLK-1:0]  lock_bits,
  input  logic              top_lock_n,
  input  logic              pe_done,
  input  logic              denied_clr,
  output logic              pe_active,
  output logic              denied,
  output logic              ev_accept,
  output logic              ev_deny,
  output logic [BLK_W-1:0]  blk_idx
);

  // Only the highest block answers to the top-lock pin.
  function automatic logic is_top(input int b);
    return b == N_BLK - 1;
  endfunction

  logic [N_BLK-1:0] prot_vec;

  for (genvar b = 0; b < N_BLK; b++) begin : g_prot
    if (is_top(b)) begin : g_top
      assign prot_vec[b] = lock_bits[b] | ~top_lock_n;
    end else begin : g_main
      assign prot_vec[b] = lock_bits[b];
    end
  end

  logic act_q;
  logic den_q;

  assign blk_idx   = addr[BLK_LSB +: BLK_W];
  assign ev_accept = pe_req && req_ok && !act_q;
  assign ev_deny   = ev_accept && prot_vec[blk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      den_q <= 1'b0;
    end else begin
      // The decision is taken once, at acceptance; pins may move afterwards.
      if (ev_accept && !ev_deny) act_q <= 1'b1;
      else if (act_q && pe_done) act_q <= 1'b0;

      if (ev_deny)         den_q <= 1'b1;
      else if (denied_clr) den_q <= 1'b0;
    end
  end

  assign pe_active = act_q;
  assign denied    = den_q;

endmodule

// File: rtl/fwh_sel_guard.sv
module fwh_sel_guard #(
  parameter int ID_W    = 4,
  parameter int ADDR_W  = 22,
  parameter int N_BLK   = 16,
  parameter int BLK_LSB = 16,
  parameter int LPC_LSB = 20,
  parameter int LPC_W   = 2
) (
  input  logic              clk,
  input  logic              bus_rst_n,
  input  logic              cpu_rst_n,
  input  logic              if_sel_i,
  input  logic              frame_n,
  input  logic              hdr_vld,
  input  logic              lpc_cyc,
  input  logic [ID_W-1:0]   cyc_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   strap_id,
  input  logic              op_done,
  input  logic              pe_req,
  input  logic              pe_done,
  input  logic [N_BLK-1:0]  lock_bits,
  input  logic              top_lock_n,
  input  logic              denied_clr,
  output logic              mux_mode,
  output logic              busy,
  output logic              abort_p,
  output logic              sel,
  output logic              drv_en,
  output logic              read_mode,
  output logic              pe_active,
  output logic              denied
);

  localparam int BLK_W = $clog2(N_BLK);

  logic             rst_n_int;
  logic             ev_start;
  logic             ev_abort;
  logic             ev_hit;
  logic             ev_accept;
  logic             ev_deny;
  logic [BLK_W-1:0] blk_idx;

  fwh_rst_mode u_rst (
    .clk       (clk),
    .bus_rst_n (bus_rst_n),
    .cpu_rst_n (cpu_rst_n),
    .if_sel_i  (if_sel_i),
    .rst_n_int (rst_n_int),
    .mux_mode  (mux_mode)
  );

  fwh_frame_trk #(
    .ID_W    (ID_W),
    .ADDR_W  (ADDR_W),
    .LPC_LSB (LPC_LSB),
    .LPC_W   (LPC_W)
  ) u_frm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .mux_mode (mux_mode),
    .frame_n  (frame_n),
    .hdr_vld  (hdr_vld),
    .lpc_cyc  (lpc_cyc),
    .cyc_id   (cyc_id),
    .addr     (addr),
    .strap_id (strap_id),
    .op_done  (op_done),
    .busy     (busy),
    .sel      (sel),
    .abort_p  (abort_p),
    .ev_start (ev_start),
    .ev_abort (ev_abort),
    .ev_hit   (ev_hit)
  );

  fwh_lock_gate #(
    .N_BLK   (N_BLK),
    .ADDR_W  (ADDR_W),
    .BLK_LSB (BLK_LSB)
  ) u_lck (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_ok     (sel | mux_mode),
    .pe_req     (pe_req),
    .addr       (addr),
    .lock_bits  (lock_bits),
    .top_lock_n (top_lock_n),
    .pe_done    (pe_done),
    .denied_clr (denied_clr),
    .pe_active  (pe_active),
    .denied     (denied),
    .ev_accept  (ev_accept),
    .ev_deny    (ev_deny),
    .blk_idx    (blk_idx)
  );

  // Outputs float (drive disabled) for as long as either reset is held.
  assign drv_en    = rst_n_int & sel;
  assign read_mode = ~pe_active;

endmodule

// File: rtl/fwh_sel_guard_chk.sv
module fwh_sel_guard_chk #(
  parameter int N_BLK  = 16,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input logic             clk,
  input logic             bus_rst_n,
  input logic             cpu_rst_n,
  input logic             frame_n,
  input logic             mux_mode,
  input logic             busy,
  input logic             abort_p,
  input logic             sel,
  input logic             drv_en,
  input logic             pe_active,
  input logic             pe_done,
  input logic             denied,
  input logic             denied_clr,
  input logic             top_lock_n,
  input logic             ev_accept,
  input logic [BLK_W-1:0] blk_idx
);

  logic rst_on;
  assign rst_on = !(bus_rst_n && cpu_rst_n);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst_on)
    $past(bus_rst_n && cpu_rst_n) |-> $stable(mux_mode));

  // R3
  frame_start_chk: assert property (@(posedge clk) disable iff (rst_on)
    (!busy && !frame_n && !mux_mode) |=> busy);

  // R4
  frame_abort_chk: assert property (@(posedge clk) disable iff (rst_on)
    (busy && !frame_n) |=> (abort_p && !busy && !sel));

  // R7
  drive_gate_chk: assert property (@(posedge clk) disable iff (rst_on)
    drv_en |-> sel);

  // R8
  mux_quiet_chk: assert property (@(posedge clk) disable iff (rst_on)
    mux_mode |-> (!busy && !sel));

  // R10
  top_block_chk: assert property (@(posedge clk) disable iff (rst_on)
    (ev_accept && blk_idx == BLK_W'(N_BLK - 1) && !top_lock_n) |=> (denied && !pe_active));

  // R11
  active_hold_chk: assert property (@(posedge clk) disable iff (rst_on)
    (pe_active && !pe_done) |=> pe_active);

  // R12
  denied_hold_chk: assert property (@(posedge clk) disable iff (rst_on)
    (denied && !denied_clr) |=> denied);

endmodule

bind fwh_sel_guard fwh_sel_guard_chk #(.N_BLK(N_BLK)) u_chk (
  .clk        (clk),
  .bus_rst_n  (bus_rst_n),
  .cpu_rst_n  (cpu_rst_n),
  .frame_n    (frame_n),
  .mux_mode   (mux_mode),
  .busy       (busy),
  .abort_p    (abort_p),
  .sel        (sel),
  .drv_en     (drv_en),
  .pe_active  (pe_active),
  .pe_done    (pe_done),
  .denied     (denied),
  .denied_clr (denied_clr),
  .top_lock_n (top_lock_n),
  .ev_accept  (ev_accept),
  .blk_idx    (blk_idx)
);

// File: tb/sim_fwh_sel_guard.sv
`timescale 1ns/1ps
module sim_fwh_sel_guard;

  logic        clk = 1'b0;
  logic        bus_rst_n = 1'b0, cpu_rst_n = 1'b1, if_sel_i = 1'b0;
  logic        frame_n = 1'b1, hdr_vld = 1'b0, lpc_cyc = 1'b0;
  logic [3:0]  cyc_id = '0, strap_id = 4'b0101;
  logic [21:0] addr = '0;
  logic        op_done = 1'b0, pe_req = 1'b0, pe_done = 1'b0;
  logic [15:0] lock_bits = '0;
  logic        top_lock_n = 1'b1, denied_clr = 1'b0;
  logic        mux_mode, busy, abort_p, sel, drv_en, read_mode, pe_active, denied;

  always #2 clk = ~clk;

  fwh_sel_guard u0 (
    .clk(clk), .bus_rst_n(bus_rst_n), .cpu_rst_n(cpu_rst_n), .if_sel_i(if_sel_i),
    .frame_n(frame_n), .hdr_vld(hdr_vld), .lpc_cyc(lpc_cyc), .cyc_id(cyc_id),
    .addr(addr), .strap_id(strap_id), .op_done(op_done), .pe_req(pe_req),
    .pe_done(pe_done), .lock_bits(lock_bits), .top_lock_n(top_lock_n),
    .denied_clr(denied_clr), .mux_mode(mux_mode), .busy(busy), .abort_p(abort_p),
    .sel(sel), .drv_en(drv_en), .read_mode(read_mode), .pe_active(pe_active),
    .denied(denied)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  // Behavioural reference state.
  bit m_mode, m_busy, m_sel, m_abort, m_act, m_den;

  always @(posedge clk) begin
    bit hit, prot, acc, n_busy, n_sel, n_abort, n_act, n_den;
    int b;
    if (!(bus_rst_n && cpu_rst_n)) begin
      m_mode = if_sel_i;
      {m_busy, m_sel, m_abort, m_act, m_den} = '0;
    end else begin
      b    = int'(addr[19:16]);
      prot = lock_bits[b] || (b == 15 && !top_lock_n);
      acc  = pe_req && (m_mode || m_sel) && !m_act;
      n_act = m_act;
      n_den = m_den;
      if (acc) begin
        if (prot) n_den = 1'b1;
        else      n_act = 1'b1;
      end else if (m_act && pe_done) n_act = 1'b0;
      if (!(acc && prot) && denied_clr) n_den = 1'b0;
      if (lpc_cyc) hit = (addr[21] != strap_id[3]) && (addr[20] != strap_id[2]);
      else         hit = (cyc_id == strap_id);
      n_busy = m_busy; n_sel = m_sel; n_abort = 1'b0;
      if (m_mode) begin
        n_busy = 1'b0; n_sel = 1'b0;
      end else if (!m_busy) begin
        if (!frame_n) begin n_busy = 1'b1; n_sel = 1'b0; end
      end else if (!frame_n) begin
        n_busy = 1'b0; n_sel = 1'b0; n_abort = 1'b1;
      end else if (op_done) begin
        n_busy = 1'b0; n_sel = 1'b0;
      end else if (hdr_vld && hit) n_sel = 1'b1;
      m_busy = n_busy; m_sel = n_sel; m_abort = n_abort; m_act = n_act; m_den = n_den;
    end
  end

  task automatic cmp(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    bit r;
    if (cmp_on && !done) begin
      r = bus_rst_n && cpu_rst_n;
      cmp(mux_mode,  m_mode,               "R2 mux_mode");
      cmp(busy,      r & m_busy,           "R3 busy");
      cmp(abort_p,   r & m_abort,          "R4 abort_p");
      cmp(sel,       r & m_sel,            "R5/R6 sel");
      cmp(drv_en,    r & m_sel,            "R7 drv_en");
      cmp(pe_active, r & m_act,            "R9 pe_active");
      cmp(read_mode, !(r & m_act),         "R11 read_mode");
      cmp(denied,    r & m_den,            "R12 denied");
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [21:0] blk_addr(input int b, input logic [1:0] hi);
    return {hi, b[3:0], 16'h0};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // r1_ reset state with interface reset
    tick(); tick(); tick();
    cmp_on = 1'b1;
    cmp(busy, 1'b0, "R1 busy in reset");
    cmp(drv_en, 1'b0, "R1 drv_en in reset");
    cmp(read_mode, 1'b1, "R1 read_mode in reset");
    cmp(denied, 1'b0, "R1 denied in reset");
    bus_rst_n = 1'b1; tick();

    // Firmware-hub select
    frame_n = 1'b0; tick();
    cmp(busy, 1'b1, "R3 start");
    frame_n = 1'b1; hdr_vld = 1'b1; cyc_id = 4'b0101; tick();
    cmp(sel, 1'b1, "R5 id match");
    cmp(drv_en, 1'b1, "R7 drive on select");
    hdr_vld = 1'b0;

    // Program in an unlocked block, pins move mid-operation
    pe_req = 1'b1; addr = blk_addr(3, 2'b00); tick();
    cmp(pe_active, 1'b1, "R9 grant blk3");
    cmp(read_mode, 1'b0, "R11 leave read");
    pe_req = 1'b0; lock_bits = '1; top_lock_n = 1'b0; tick();
    cmp(pe_active, 1'b1, "R11 pins ignored");
    pe_done = 1'b1; tick(); pe_done = 1'b0;
    cmp(pe_active, 1'b0, "R11 done");
    cmp(read_mode, 1'b1, "R11 back to read");

    // Locked block
    pe_req = 1'b1; addr = blk_addr(3, 2'b00); tick(); pe_req = 1'b0;
    cmp(denied, 1'b1, "R9 locked deny");
    cmp(pe_active, 1'b0, "R9 no start");
    tick();
    cmp(denied, 1'b1, "R12 sticky");
    pe_req = 1'b1; denied_clr = 1'b1; tick(); pe_req = 1'b0;
    cmp(denied, 1'b1, "R12 set beats clear");
    tick(); denied_clr = 1'b0;
    cmp(denied, 1'b0, "R12 clear");

    // Top block lock pin
    lock_bits = '0; top_lock_n = 1'b0;
    pe_req = 1'b1; addr = blk_addr(15, 2'b00); tick(); pe_req = 1'b0;
    cmp(denied, 1'b1, "R10 blk15 pin lock");
    cmp(pe_active, 1'b0, "R10 blk15 no start");
    denied_clr = 1'b1; tick(); denied_clr = 1'b0;
    pe_req = 1'b1; addr = blk_addr(14, 2'b00); tick(); pe_req = 1'b0;
    cmp(pe_active, 1'b1, "R10 blk14 ignores pin");
    pe_done = 1'b1; tick(); pe_done = 1'b0;
    top_lock_n = 1'b1;
    pe_req = 1'b1; addr = blk_addr(15, 2'b00); tick(); pe_req = 1'b0;
    cmp(pe_active, 1'b1, "R10 blk15 pin released");
    pe_done = 1'b1; tick(); pe_done = 1'b0;

    op_done = 1'b1; tick(); op_done = 1'b0;
    cmp(busy, 1'b0, "R7 done clears busy");
    cmp(drv_en, 1'b0, "R7 drive off");

    // Firmware-hub miss
    frame_n = 1'b0; tick(); frame_n = 1'b1;
    hdr_vld = 1'b1; cyc_id = 4'b0100; tick(); hdr_vld = 1'b0;
    cmp(sel, 1'b0, "R5 id miss");
    op_done = 1'b1; tick(); op_done = 1'b0;

    // LPC matching with inverted upper straps
    strap_id = 4'b0110; lpc_cyc = 1'b1;
    frame_n = 1'b0; tick(); frame_n = 1'b1;
    hdr_vld = 1'b1; addr = blk_addr(0, 2'b10); cyc_id = 4'b1111; tick(); hdr_vld = 1'b0;
    cmp(sel, 1'b1, "R6 lpc hit");
    op_done = 1'b1; tick(); op_done = 1'b0;
    strap_id = 4'b0101;
    frame_n = 1'b0; tick(); frame_n = 1'b1;
    hdr_vld = 1'b1; addr = blk_addr(0, 2'b10); tick(); hdr_vld = 1'b0;
    cmp(sel, 1'b1, "R6 low straps ignored");
    op_done = 1'b1; tick(); op_done = 1'b0;
    frame_n = 1'b0; tick(); frame_n = 1'b1;
    hdr_vld = 1'b1; addr = blk_addr(0, 2'b01); tick(); hdr_vld = 1'b0;
    cmp(sel, 1'b0, "R6 lpc miss");
    op_done = 1'b1; tick(); op_done = 1'b0;

    // Abort colliding with a matching header
    lpc_cyc = 1'b0; cyc_id = 4'b0101;
    frame_n = 1'b0; tick();
    hdr_vld = 1'b1; tick(); hdr_vld = 1'b0; frame_n = 1'b1;
    cmp(abort_p, 1'b1, "R4 abort pulse");
    cmp(sel, 1'b0, "R4 abort beats match");
    cmp(busy, 1'b0, "R4 abort idles");
    tick();
    cmp(abort_p, 1'b0, "R4 single pulse");

    // Processor reset alone, mode capture
    cpu_rst_n = 1'b0; if_sel_i = 1'b1; #1;
    cmp(drv_en, 1'b0, "R1 cpu reset drive off");
    tick(); tick();
    cmp(mux_mode, 1'b1, "R2 captured in reset");
    cpu_rst_n = 1'b1; tick(); if_sel_i = 1'b0; tick();
    cmp(mux_mode, 1'b1, "R2 held after reset");
    frame_n = 1'b0; tick(); frame_n = 1'b1;
    cmp(busy, 1'b0, "R8 no frame tracking");
    pe_req = 1'b1; addr = blk_addr(2, 2'b00); tick(); pe_req = 1'b0;
    cmp(pe_active, 1'b1, "R9 mux-mode request");
    pe_done = 1'b1; tick(); pe_done = 1'b0;

    bus_rst_n = 1'b0; tick(); bus_rst_n = 1'b1; tick();
    cmp(mux_mode, 1'b0, "R2 recaptured");

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      frame_n    = ($urandom_range(0, 5) != 0);
      hdr_vld    = $urandom_range(0, 1);
      lpc_cyc    = $urandom_range(0, 1);
      cyc_id     = 4'($urandom_range(4, 6));
      addr       = 22'($urandom);
      op_done    = ($urandom_range(0, 7) == 0);
      pe_req     = $urandom_range(0, 1);
      pe_done    = ($urandom_range(0, 3) == 0);
      lock_bits  = 16'($urandom);
      top_lock_n = $urandom_range(0, 1);
      denied_clr = ($urandom_range(0, 3) == 0);
      cpu_rst_n  = ($urandom_range(0, 150) != 0);
      if_sel_i   = ($urandom_range(0, 7) == 0);
      tick();
    end
    cpu_rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule